// File: doc/BRIEF.md
# Staged AXI4 Write Burst Master

This block takes data words from a slow source (a FIFO that offers a new word only every few clock cycles) and writes them to a memory-mapped slave over the AXI4 write address, write data and write response channels. It does not forward words as they arrive. Instead it gathers one burst's worth of words in a local staging buffer. It then issues a single address request and sends all beats back to back. Because AXI4 does not allow write interleaving, this keeps the shared write channel busy only for as long as the burst itself takes.

The block repeats a fixed cycle. It samples the start address and beat count, fills the buffer, sends the address, drains the data and waits for the single write response. The source is stalled for every phase except the fill. A response other than OKAY sets a sticky error flag. The flag stays set until it is cleared by a pulse on `err_clear`.

Top module: `axi_burst_stager`

## Requirements
- R1: During reset and in the cycle that follows it, `awvalid`, `wvalid`, `bready`, `src_ready` and `err_flag` are all low.
- R2: `src_ready` is high only during the fill phase. It is low whenever `awvalid`, `wvalid` or `bready` is high.
- R3: `awvalid` rises only after exactly `cfg_len`+1 source words have been accepted for the burst. The address request carries the sampled start address and `awlen` = `cfg_len` (number of beats minus one). It also carries `awsize` = log2 of the bus width in bytes (2 for 32-bit data) and `awburst` = 2'b01 (incrementing). These values stay stable while `awready` is low.
- R4: Once the first beat is presented, `wvalid` stays high on every cycle until the final beat is accepted. The data phase has no idle gaps.
- R5: Beats carry the buffered words in the order the source delivered them.
- R6: Exactly `awlen`+1 beats are accepted per burst, and `wlast` is high on the final beat only.
- R7: While `wvalid` is high and `wready` is low, `wvalid`, `wdata`, `wstrb` and `wlast` hold their values.
- R8: `wstrb` is all ones on every beat.
- R9: After the last beat, `bready` is held high until `bvalid` is seen. No new fill begins before that single response is taken.
- R10: A response with `bresp` not equal to 2'b00 (OKAY) sets `err_flag` on the next cycle. The flag stays set until an `err_clear` pulse clears it. A setting response wins over a clear in the same cycle.
- R11: `cfg_addr` and `cfg_len` are sampled once, at the start of each burst. A `cfg_len` larger than the buffer depth minus one is clamped to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 1 | Source word available |
| src_ready | output | 1 | Block accepts a source word |
| src_data | input | DATA_W | Source word |
| cfg_addr | input | ADDR_W | Start address of the next burst |
| cfg_len | input | 8 | Beats minus one for the next burst |
| err_clear | input | 1 | Clears the sticky error flag |
| err_flag | output | 1 | Sticky error-response flag |
| awvalid | output | 1 | Address request valid |
| awready | input | 1 | Slave accepts address |
| awaddr | output | ADDR_W | Burst start address |
| awlen | output | 8 | Beats minus one |
| awsize | output | 3 | Beat size code |
| awburst | output | 2 | Burst type (incrementing) |
| wvalid | output | 1 | Write beat valid |
| wready | input | 1 | Slave accepts beat |
| wdata | output | DATA_W | Beat data |
| wstrb | output | DATA_W/8 | Byte enables |
| wlast | output | 1 | Final beat of burst |
| bvalid | input | 1 | Response valid |
| bready | output | 1 | Block accepts response |
| bresp | input | 2 | Response code |

## Verification
Every control output is decoded from registered state, so it appears one clock edge after the event that caused it. The address request follows the edge that accepts the last fill word. The first beat follows the edge of the address handshake. The error flag changes on the edge after the response handshake. The bench drives the slave-side inputs and samples all outputs together on the falling edge. It decides whether a handshake happens at the next rising edge from the values it sees there. This means each expected value is compared in the first half-cycle after the edge that should have produced it. The stall-hold and gap checks compare each falling-edge sample against the one taken a full cycle earlier.

// File: rtl/axwb_pkg.sv
package axwb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_ADDR,
        ST_DATA,
        ST_RESP
    } axwb_state_e;

    localparam logic [1:0] BURST_INCR = 2'b01;
    localparam logic [1:0] RESP_OKAY  = 2'b00;
    localparam int         AXLEN_W    = 8;

    // beat size code: log2 of bytes per beat
    function automatic logic [2:0] size_code(input int data_w);
        int bytes;
        logic [2:0] code;
        bytes = data_w / 8;
        code  = 3'd0;
        for (int i = 0; i < 8; i++) begin
            if ((1 << i) == bytes) code = 3'(i);
        end
        return code;
    endfunction

endpackage

// File: rtl/axwb_stage_buf.sv
module axwb_stage_buf #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/axwb_ctrl.sv
module axwb_ctrl
    import axwb_pkg::*;
#(
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               src_valid,
    input  logic [AXLEN_W-1:0] cfg_len,
    input  logic               awready,
    input  logic               wready,
    input  logic               bvalid,
    input  logic [1:0]         bresp,
    input  logic               err_clear,
    output axwb_state_e        state,
    output logic               src_ready,
    output logic               fill_en,
    output logic [IDX_W-1:0]   fill_idx,
    output logic [IDX_W-1:0]   beat_idx,
    output logic [IDX_W-1:0]   len_q,
    output logic               awvalid,
    output logic               wvalid,
    output logic               wlast,
    output logic               bready,
    output logic               err_flag
);

    localparam logic [AXLEN_W-1:0] LEN_CAP = AXLEN_W'(DEPTH - 1);

    axwb_state_e state_d;
    logic [IDX_W-1:0] len_clamped;

    assign len_clamped = (cfg_len > LEN_CAP) ? IDX_W'(LEN_CAP) : IDX_W'(cfg_len);

    assign src_ready = (state == ST_FILL);
    assign fill_en   = src_ready && src_valid;
    assign awvalid   = (state == ST_ADDR);
    assign wvalid    = (state == ST_DATA);
    assign wlast     = wvalid && (beat_idx == len_q);
    assign bready    = (state == ST_RESP);

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: state_d = ST_FILL;
            ST_FILL: if (fill_en && fill_idx == len_q) state_d = ST_ADDR;
            ST_ADDR: if (awready) state_d = ST_DATA;
            ST_DATA: if (wready && wlast) state_d = ST_RESP;
            ST_RESP: if (bvalid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            fill_idx <= '0;
            beat_idx <= '0;
            len_q    <= '0;
            err_flag <= 1'b0;
        end else begin
            state <= state_d;
            if (state == ST_IDLE) begin
                len_q    <= len_clamped;
                fill_idx <= '0;
            end else if (fill_en) begin
                fill_idx <= fill_idx + 1'b1;
            end
            if (state == ST_ADDR) beat_idx <= '0;
            else if (wvalid && wready && !wlast) beat_idx <= beat_idx + 1'b1;
            if (bready && bvalid && bresp != RESP_OKAY) err_flag <= 1'b1;
            else if (err_clear) err_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/axi_burst_stager.sv
module axi_burst_stager
    import axwb_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 32,
    parameter int MAX_BEATS = 16,
    localparam int STRB_W   = DATA_W / 8,
    localparam int IDX_W    = $clog2(MAX_BEATS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               src_valid,
    output logic               src_ready,
    input  logic [DATA_W-1:0]  src_data,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [AXLEN_W-1:0] cfg_len,
    input  logic               err_clear,
    output logic               err_flag,
    output logic               awvalid,
    input  logic               awready,
    output logic [ADDR_W-1:0]  awaddr,
    output logic [AXLEN_W-1:0] awlen,
    output logic [2:0]         awsize,
    output logic [1:0]         awburst,
    output logic               wvalid,
    input  logic               wready,
    output logic [DATA_W-1:0]  wdata,
    output logic [STRB_W-1:0]  wstrb,
    output logic               wlast,
    input  logic               bvalid,
    output logic               bready,
    input  logic [1:0]         bresp
);

    axwb_state_e      state;
    logic             fill_en;
    logic [IDX_W-1:0] fill_idx;
    logic [IDX_W-1:0] beat_idx;
    logic [IDX_W-1:0] len_q;
    logic [ADDR_W-1:0] addr_q;

    axwb_ctrl #(.DEPTH(MAX_BEATS)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .src_valid(src_valid),
        .cfg_len  (cfg_len),
        .awready  (awready),
        .wready   (wready),
        .bvalid   (bvalid),
        .bresp    (bresp),
        .err_clear(err_clear),
        .state    (state),
        .src_ready(src_ready),
        .fill_en  (fill_en),
        .fill_idx (fill_idx),
        .beat_idx (beat_idx),
        .len_q    (len_q),
        .awvalid  (awvalid),
        .wvalid   (wvalid),
        .wlast    (wlast),
        .bready   (bready),
        .err_flag (err_flag)
    );

    axwb_stage_buf #(.DATA_W(DATA_W), .DEPTH(MAX_BEATS)) u_buf (
        .clk    (clk),
        .wr_en  (fill_en),
        .wr_idx (fill_idx),
        .wr_data(src_data),
        .rd_idx (beat_idx),
        .rd_data(wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) addr_q <= '0;
        else if (state == ST_IDLE) addr_q <= cfg_addr;
    end

    assign awaddr  = addr_q;
    assign awlen   = AXLEN_W'(len_q);
    assign awsize  = size_code(DATA_W);
    assign awburst = BURST_INCR;
    assign wstrb   = '1;

endmodule

// File: rtl/axwb_checker.sv
module axwb_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              src_ready,
    input logic              awvalid,
    input logic              awready,
    input logic [ADDR_W-1:0] awaddr,
    input logic [7:0]        awlen,
    input logic              wvalid,
    input logic              wready,
    input logic [DATA_W-1:0] wdata,
    input logic              wlast,
    input logic              bvalid,
    input logic              bready,
    input logic [1:0]        bresp,
    input logic              err_flag
);

    p_src_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (awvalid || wvalid || bready) |-> !src_ready);

    p_aw_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (awvalid && !awready) |=> (awvalid && $stable(awaddr) && $stable(awlen)));

    p_no_gap_r4: assert property (@(posedge clk) disable iff (rst)
        (wvalid && wready && !wlast) |=> wvalid);

    p_w_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (wvalid && !wready) |=> (wvalid && $stable(wdata) && $stable(wlast)));

    p_resp_wait_r9: assert property (@(posedge clk) disable iff (rst)
        (wvalid && wready && wlast) |=> bready);

    p_bready_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (bready && !bvalid) |=> bready);

    p_err_set_r10: assert property (@(posedge clk) disable iff (rst)
        (bvalid && bready && bresp != 2'b00) |=> err_flag);

endmodule

bind axi_burst_stager axwb_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_axwb_chk (
    .clk      (clk),
    .rst      (rst),
    .src_ready(src_ready),
    .awvalid  (awvalid),
    .awready  (awready),
    .awaddr   (awaddr),
    .awlen    (awlen),
    .wvalid   (wvalid),
    .wready   (wready),
    .wdata    (wdata),
    .wlast    (wlast),
    .bvalid   (bvalid),
    .bready   (bready),
    .bresp    (bresp),
    .err_flag (err_flag)
);

// File: tb/axi_burst_stager_bench.sv
module axi_burst_stager_bench;

    localparam int DW = 32;
    localparam int AW = 32;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst;
    logic          src_valid, src_ready;
    logic [DW-1:0] src_data;
    logic [AW-1:0] cfg_addr;
    logic [7:0]    cfg_len;
    logic          err_clear, err_flag;
    logic          awvalid, awready;
    logic [AW-1:0] awaddr;
    logic [7:0]    awlen;
    logic [2:0]    awsize;
    logic [1:0]    awburst;
    logic          wvalid, wready, wlast;
    logic [DW-1:0] wdata;
    logic [3:0]    wstrb;
    logic          bvalid, bready;
    logic [1:0]    bresp;

    axi_burst_stager u_axi_burst_stager (
        .clk(clk), .rst(rst),
        .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
        .cfg_addr(cfg_addr), .cfg_len(cfg_len),
        .err_clear(err_clear), .err_flag(err_flag),
        .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
        .awlen(awlen), .awsize(awsize), .awburst(awburst),
        .wvalid(wvalid), .wready(wready), .wdata(wdata),
        .wstrb(wstrb), .wlast(wlast),
        .bvalid(bvalid), .bready(bready), .bresp(bresp)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic [AW-1:0] t_addr [3] = '{32'h0000_1000, 32'h0000_2040, 32'h0000_3000};
    int            t_len  [3] = '{3, 7, 0};
    logic [1:0]    t_resp [3] = '{2'b00, 2'b10, 2'b00};

    logic [DW-1:0] expq [$];
    int accepted = 0;

    // driver: one word every four cycles, expected item queued at acceptance
    task automatic send(input logic [DW-1:0] w);
        @(negedge clk);
        src_valid = 1'b1;
        src_data  = w;
        while (!src_ready) @(negedge clk);
        expq.push_back(w);
        accepted++;
        @(negedge clk);
        src_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; src_valid = 1'b0; src_data = '0;
        cfg_addr = t_addr[0]; cfg_len = 8'(t_len[0]); err_clear = 1'b0;
        awready = 1'b0; wready = 1'b0; bvalid = 1'b0; bresp = 2'b00;
        repeat (3) @(negedge clk);
        check(!awvalid && !wvalid && !bready && !src_ready && !err_flag, "R1 reset outputs",
              {awvalid, wvalid, bready, src_ready, err_flag}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!awvalid && !wvalid && !bready && !err_flag, "R1 first cycle",
              {awvalid, wvalid, bready, err_flag}, 0);
        for (int i = 0; i < 13; i++) send(32'hA500_0000 + 32'(i * 37));
    end

    // slave model and monitor
    int  cyc = 0, aw_wait = 0, aw_cnt = 0, b_cnt = 0, b_wait = 0;
    int  base_acc = 0, beats = 0, gaps = 0, clear_at = -1;
    bit  started = 0, prev_stall = 0, drop_b = 0, exp_err = 0;
    logic [DW-1:0] prev_data, expw;
    logic          prev_last;

    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (drop_b) begin bvalid = 1'b0; drop_b = 0; end
            if (awvalid) aw_wait++; else aw_wait = 0;
            awready = (aw_wait >= 3);
            wready  = (aw_cnt == 2) ? ((cyc % 3) != 1) : 1'b1;
            if (b_wait > 0) begin
                b_wait--;
                if (b_wait == 0) bvalid = 1'b1;
            end
            bresp     = (b_cnt < 3) ? t_resp[b_cnt] : 2'b00;
            err_clear = (cyc == clear_at);

            check(err_flag == exp_err, "R10 sticky flag", err_flag, exp_err);

            if (prev_stall)
                check(wvalid && wdata == prev_data && wlast == prev_last, "R7 hold on stall",
                      wdata, prev_data);

            if (awvalid && awready && aw_cnt < 3) begin
                check(awaddr == t_addr[aw_cnt], "R11 address sampled", awaddr, t_addr[aw_cnt]);
                check(awlen == 8'(t_len[aw_cnt]), "R3 awlen", awlen, t_len[aw_cnt]);
                check(awsize == 3'd2 && awburst == 2'b01, "R3 size/burst", {awsize, awburst}, 5'b01001);
                check(accepted - base_acc == t_len[aw_cnt] + 1, "R3 words before AW",
                      accepted - base_acc, t_len[aw_cnt] + 1);
                check(!src_ready, "R2 source stalled", src_ready, 0);
                base_acc += t_len[aw_cnt] + 1;
                aw_cnt++;
                if (aw_cnt < 3) begin
                    cfg_addr = t_addr[aw_cnt];
                    cfg_len  = 8'(t_len[aw_cnt]);
                end
            end

            if (wvalid) started = 1;
            else if (started) gaps++;

            if (wvalid && wready) begin
                expw = (expq.size() > 0) ? expq.pop_front() : '0;
                check(wdata == expw, "R5 beat order", wdata, expw);
                check(wstrb == 4'hF, "R8 strobes", wstrb, 4'hF);
                beats++;
                if (wlast) begin
                    check(beats == t_len[aw_cnt-1] + 1, "R6 beat count", beats, t_len[aw_cnt-1] + 1);
                    check(gaps == 0, "R4 no gaps", gaps, 0);
                    started = 0; gaps = 0; beats = 0; b_wait = 2;
                end
            end
            prev_stall = wvalid && !wready;
            prev_data  = wdata;
            prev_last  = wlast;

            if (bvalid && bready) begin
                check(!src_ready, "R9 no fill before response", src_ready, 0);
                exp_err = (bresp != 2'b00) ? 1 : (err_clear ? 0 : exp_err);
                b_cnt++;
                drop_b = 1;
                if (b_cnt == 2) clear_at = cyc + 3;
            end else if (err_clear) begin
                exp_err = 0;
            end
        end
    end

    initial begin
        while (b_cnt < 3 && cyc < 20000) @(negedge clk);
        if (b_cnt < 3) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", b_cnt, 3);
        end
        repeat (4) @(negedge clk);
        check(expq.size() == 0, "R5 all words sent", expq.size(), 0);
        check(err_flag == 1'b0, "R10 cleared", err_flag, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule